// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block is the tag and state directory of a set-associative cache. For every way of every set it records which line address is held, an access permission for the line, and an optional lock owner (a context ID). The data array lives elsewhere. A cache controller sends one line-aligned address per request, together with an operation code. The block answers with a registered response one cycle later. The operations are: access check, availability check, allocation, deallocation, victim probe, recency touch, permission write, and lock set, clear and test.

The set is chosen by an address field that starts at a configurable bit, and the number of sets is derived from the cache size, the associativity and the line size. Each set keeps a true-LRU ordering of its ways. An access hit, a touch and a successful allocation each make the addressed way most recently used. A probe names the least recently used way as the victim. A line is visible to lookups only while its permission is not NotPresent. A line whose permission is NotPresent still occupies a way, but that way counts as free.

Top module: `tagdir_top`

## Requirements
- R1: The set index is `req_addr[START_BIT +: log2(NUM_SETS)]`, with NUM_SETS = CACHE_BYTES / WAYS / LINE_BYTES (greater than 1). Lines in different sets never affect each other, even when the bits above the set field are equal.
- R2: `req_ready` is low in reset and high from the first clock edge after reset is released. A request accepted on an edge (`req_valid && req_ready`) gives exactly one `rsp_valid` pulse on the following edge. No response appears without an accepted request.
- R3: After reset every way is empty, so an access to any address responds with `rsp_hit`=0 and `rsp_ok`=0.
- R4: `rsp_hit` is 1 only when a way of the set holds the line address and its permission is not NotPresent (permission code 0). A matching way with permission NotPresent gives `rsp_hit`=0.
- R5: The access op (code 0) sets `rsp_ok`=1 when the line hits and either its permission is ReadWrite (3), or its permission is ReadOnly (2) and the request type is load (0) or instruction fetch (1). Store (2) and atomic (3) on ReadOnly fail, and so does Invalid (1). `rsp_way` gives the hit way.
- R6: The availability op (code 1) sets `rsp_ok`=1 when a valid way holds the address at any permission, or when any way of the set is empty or NotPresent.
- R7: The allocation op (code 2) fills the lowest-numbered empty or NotPresent way and reports it on `rsp_way` with `rsp_ok`=1. It writes permission Invalid, clears the lock owner and makes the way most recently used.
- R8: Allocating an address that already hits, or allocating into a set with no empty or NotPresent way, sets `rsp_err`=1 and `rsp_ok`=0 and leaves the set's contents and recency unchanged.
- R9: The deallocation op (code 3) empties the hit way and sets `rsp_ok`=1. On a miss it sets `rsp_err`=1.
- R10: The probe op (code 4), on a set with no available way, returns on `rsp_addr` the line address (offset bits zero) held by the least recently used way, with `rsp_ok`=1. Recency is updated by access hits, touches and allocations only. If the set has an available way, the probe sets `rsp_err`=1.
- R11: The lock-set op (7) stores `req_ctx` as owner of a hit line, and lock-clear (8) removes the owner. Lock-test (9) sets `rsp_ok`=1 only when an owner is present and equals `req_ctx`. Any of the three on a miss sets `rsp_err`=1.
- R12: The permission-write op (6) stores `req_perm` into the hit line with `rsp_ok`=1. On a miss it sets `rsp_err`=1. Unassigned op codes (10 to 15) set `rsp_err`=1.
- R13: The touch op (5) makes a hit way most recently used and sets `rsp_ok`=`rsp_hit`. It never sets `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_type | input | 2 | Request type for the access op: 0 load, 1 fetch, 2 store, 3 atomic |
| req_perm | input | 2 | Permission for the permission-write op: 0 NotPresent, 1 Invalid, 2 ReadOnly, 3 ReadWrite |
| req_ctx | input | CTX_W | Context ID for the lock ops |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_hit | output | 1 | Address was present before the operation |
| rsp_ok | output | 1 | Operation-specific success or test result |
| rsp_err | output | 1 | Operation not allowed in the current state |
| rsp_way | output | WAY_W | Hit, allocated or victim way |
| rsp_addr | output | ADDR_W | Victim line address for the probe op |

## Verification
A corrupted tag or valid bit shows on the next access or availability response for that set, as a wrong hit flag or a wrong way number. A wrong permission or lock owner shows only when an access or lock-test response reads that line. A fault in the recency ordering stays hidden until the set is full and probed, and then shows as a wrong victim address. The sequence therefore fills a set, reorders it with hits and touches, and probes it after each change, so that a stale age shows within a few requests. A NotPresent line is reused by an allocation to show that a lock left over from the old line is cleared.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [3:0] {
        OP_ACCESS   = 4'd0,
        OP_AVAIL    = 4'd1,
        OP_ALLOC    = 4'd2,
        OP_DEALLOC  = 4'd3,
        OP_PROBE    = 4'd4,
        OP_TOUCH    = 4'd5,
        OP_SETPERM  = 4'd6,
        OP_LOCKSET  = 4'd7,
        OP_LOCKCLR  = 4'd8,
        OP_LOCKTEST = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        PERM_NP  = 2'd0,
        PERM_INV = 2'd1,
        PERM_RO  = 2'd2,
        PERM_RW  = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_IFETCH = 2'd1,
        RQ_STORE  = 2'd2,
        RQ_ATOMIC = 2'd3
    } rqt_e;

    // read-only lines serve loads and fetches, read-write lines serve all
    function automatic logic perm_grants(input logic [1:0] p, input logic [1:0] t);
        return (p == PERM_RW) ||
               ((p == PERM_RO) && ((t == RQ_LOAD) || (t == RQ_IFETCH)));
    endfunction

endpackage

// File: rtl/tagdir_match.sv
module tagdir_match #(
    parameter int WAYS  = 4,
    parameter int LA_W  = 26,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]           row_vld,
    input  logic [WAYS-1:0][1:0]      row_perm,
    input  logic [WAYS-1:0][LA_W-1:0] row_tag,
    input  logic [LA_W-1:0]           line,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way,
    output logic                      avail,
    output logic                      free_any,
    output logic [WAY_W-1:0]          free_way
);
    import tagdir_pkg::*;

    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] live;
    logic [WAYS-1:0] free;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            tag_eq[w] = row_vld[w] && (row_tag[w] == line);
            live[w]   = tag_eq[w] && (row_perm[w] != PERM_NP);
            free[w]   = !row_vld[w] || (row_perm[w] == PERM_NP);
        end
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (live[w]) hit_way  = WAY_W'(w);
            if (free[w]) free_way = WAY_W'(w);
        end
    end

    assign hit      = |live;
    assign free_any = |free;
    assign avail    = (|tag_eq) || free_any;

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
    parameter int NUM_SETS = 4,
    parameter int WAYS     = 4,
    parameter int SET_W    = 2,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);
    // age 0 is most recent, WAYS-1 is least recent; ages of a set form a permutation
    logic [NUM_SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;
    logic [WAY_W-1:0] cur_age;

    assign cur_age = age_q[touch_set][touch_way];

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[touch_set][w] < cur_age)
                    age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
            end
            age_d[touch_set][touch_way] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            age_q <= age_d;
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_set][w] == WAY_W'(WAYS - 1))
                victim_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 64,
    parameter int START_BIT   = 6,
    parameter int CTX_W       = 4,
    localparam int WAY_W      = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    input  logic [1:0]        req_perm,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr
);
    import tagdir_pkg::*;

    localparam int NUM_SETS = CACHE_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int LA_W     = ADDR_W - OFF_W;

    typedef struct packed {
        logic [NUM_SETS-1:0][WAYS-1:0]            vld;
        logic [NUM_SETS-1:0][WAYS-1:0][1:0]       perm;
        logic [NUM_SETS-1:0][WAYS-1:0][LA_W-1:0]  tag;
        logic [NUM_SETS-1:0][WAYS-1:0]            lkv;
        logic [NUM_SETS-1:0][WAYS-1:0][CTX_W-1:0] lko;
        logic                                     rdy;
        logic                                     rv;
        logic                                     hit;
        logic                                     ok;
        logic                                     err;
        logic [WAY_W-1:0]                         way;
        logic [ADDR_W-1:0]                        addr;
    } state_t;

    state_t st_d, st_q;

    logic [SET_W-1:0]          set_idx;
    logic [LA_W-1:0]           line;
    logic                      unused_low;
    logic [WAYS-1:0]           row_vld;
    logic [WAYS-1:0][1:0]      row_perm;
    logic [WAYS-1:0][LA_W-1:0] row_tag;
    logic                      m_hit, m_avail, m_free_any;
    logic [WAY_W-1:0]          m_way, m_free_way, victim;
    logic                      touch_en;
    logic [WAY_W-1:0]          touch_way;
    logic                      accept;
    op_e                       op;

    assign set_idx    = req_addr[START_BIT +: SET_W];
    assign line       = req_addr[ADDR_W-1:OFF_W];
    assign unused_low = ^req_addr[OFF_W-1:0];
    assign row_vld    = st_q.vld[set_idx];
    assign row_perm   = st_q.perm[set_idx];
    assign row_tag    = st_q.tag[set_idx];
    assign accept     = req_valid && st_q.rdy;
    assign op         = op_e'(req_op);

    tagdir_match #(
        .WAYS (WAYS),
        .LA_W (LA_W),
        .WAY_W(WAY_W)
    ) u_match (
        .row_vld (row_vld),
        .row_perm(row_perm),
        .row_tag (row_tag),
        .line    (line),
        .hit     (m_hit),
        .hit_way (m_way),
        .avail   (m_avail),
        .free_any(m_free_any),
        .free_way(m_free_way)
    );

    tagdir_lru #(
        .NUM_SETS(NUM_SETS),
        .WAYS    (WAYS),
        .SET_W   (SET_W),
        .WAY_W   (WAY_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_set (set_idx),
        .touch_way (touch_way),
        .query_set (set_idx),
        .victim_way(victim)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rdy  = 1'b1;
        st_d.rv   = accept;
        touch_en  = 1'b0;
        touch_way = m_way;
        if (accept) begin
            st_d.hit  = m_hit;
            st_d.ok   = 1'b0;
            st_d.err  = 1'b0;
            st_d.way  = m_way;
            st_d.addr = '0;
            case (op)
                OP_ACCESS: begin
                    st_d.ok  = m_hit && perm_grants(row_perm[m_way], req_type);
                    touch_en = m_hit;
                end
                OP_AVAIL: begin
                    st_d.ok = m_avail;
                end
                OP_ALLOC: begin
                    if (m_hit || !m_free_any) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.vld[set_idx][m_free_way]  = 1'b1;
                        st_d.tag[set_idx][m_free_way]  = line;
                        st_d.perm[set_idx][m_free_way] = PERM_INV;
                        st_d.lkv[set_idx][m_free_way]  = 1'b0;
                        st_d.lko[set_idx][m_free_way]  = '0;
                        st_d.ok                        = 1'b1;
                        st_d.way                       = m_free_way;
                        touch_en                       = 1'b1;
                        touch_way                      = m_free_way;
                    end
                end
                OP_DEALLOC: begin
                    if (m_hit) begin
                        st_d.vld[set_idx][m_way]  = 1'b0;
                        st_d.perm[set_idx][m_way] = PERM_NP;
                        st_d.lkv[set_idx][m_way]  = 1'b0;
                        st_d.ok                   = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_PROBE: begin
                    st_d.way  = victim;
                    st_d.addr = {row_tag[victim], {OFF_W{1'b0}}};
                    st_d.ok   = !m_avail;
                    st_d.err  = m_avail;
                end
                OP_TOUCH: begin
                    st_d.ok  = m_hit;
                    touch_en = m_hit;
                end
                OP_SETPERM: begin
                    if (m_hit) begin
                        st_d.perm[set_idx][m_way] = req_perm;
                        st_d.ok                   = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_LOCKSET: begin
                    if (m_hit) begin
                        st_d.lkv[set_idx][m_way] = 1'b1;
                        st_d.lko[set_idx][m_way] = req_ctx;
                        st_d.ok                  = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_LOCKCLR: begin
                    if (m_hit) begin
                        st_d.lkv[set_idx][m_way] = 1'b0;
                        st_d.ok                  = 1'b1;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_LOCKTEST: begin
                    if (m_hit) begin
                        st_d.ok = st_q.lkv[set_idx][m_way] &&
                                  (st_q.lko[set_idx][m_way] == req_ctx);
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                default: begin
                    st_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.rdy;
    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.hit;
    assign rsp_ok    = st_q.ok;
    assign rsp_err   = st_q.err;
    assign rsp_way   = st_q.way;
    assign rsp_addr  = st_q.addr;

endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_ok,
    input logic       rsp_err
);
    import tagdir_pkg::*;

    logic [3:0] last_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_op <= '0;
        else if (req_valid && req_ready) last_op <= req_op;
    end

    // R2: one response per accepted request, one cycle later
    a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    a_r2_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> req_ready);

    // R5: access permission granted only for a present line
    a_r5_grant_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_op == OP_ACCESS && rsp_ok) |-> rsp_hit);

    // R7: a successful allocation targets an absent line
    a_r7_alloc_ok_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_op == OP_ALLOC && rsp_ok) |-> !rsp_hit);

    // R8: an error response never also reports success
    a_r8_err_excludes_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !rsp_ok);

    // R13: touch never errors
    a_r13_touch_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_op == OP_TOUCH) |-> !rsp_err);

endmodule

bind tagdir_top tagdir_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (req_op),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_ok   (rsp_ok),
    .rsp_err  (rsp_err)
);

// File: tb/tb_tagdir_top.sv
`timescale 1ns/1ps
module tb_tagdir_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_type = '0;
    logic [1:0]  req_perm = '0;
    logic [3:0]  req_ctx = '0;
    logic        rsp_valid, rsp_hit, rsp_ok, rsp_err;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tagdir_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_type(req_type), .req_perm(req_perm),
        .req_ctx(req_ctx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_way(rsp_way),
        .rsp_addr(rsp_addr)
    );

    typedef struct {
        int          hit;
        bit          ok;
        bit          err;
        int          way;
        bit          ca;
        logic [31:0] addr;
        string       rq;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit good, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int t, input int s);
        return 32'((t << 8) | (s << 6));
    endfunction

    task automatic send(input logic [3:0] op, input logic [31:0] a,
                        input logic [1:0] rt, input logic [1:0] pm,
                        input logic [3:0] cx, input int eh, input bit eo,
                        input bit ee, input int ew, input bit ca,
                        input logic [31:0] ea, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        req_type = rt; req_perm = pm; req_ctx = cx;
        e.hit = eh; e.ok = eo; e.err = ee; e.way = ew;
        e.ca = ca; e.addr = ea; e.rq = rq;
        sb.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // monitor: responses are registered, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_ok == e.ok, e.rq, "ok", rsp_ok, e.ok);
                chk(rsp_err == e.err, e.rq, "err", rsp_err, e.err);
                if (e.hit >= 0) chk(rsp_hit == e.hit[0], e.rq, "hit", rsp_hit, e.hit);
                if (e.way >= 0) chk(rsp_way == 2'(e.way), e.rq, "way", rsp_way, e.way);
                if (e.ca) chk(rsp_addr == e.addr, e.rq, "addr", rsp_addr, e.addr);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "watchdog", "timeout", cyc, 20000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    localparam logic [3:0] ACC = 0, AVL = 1, ALC = 2, DAL = 3, PRB = 4,
                           TCH = 5, SPM = 6, LKS = 7, LKC = 8, LKT = 9;

    initial begin
        logic [31:0] a_, b_, c_, d_;
        a_ = mk(1, 1); b_ = mk(2, 1); c_ = mk(3, 1); d_ = mk(4, 1);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R2", "ready in reset", req_ready, 0);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);

        // R3 empty after reset
        send(ACC, a_, 0, 0, 0, 0, 0, 0, -1, 0, 0, "R3 empty access");
        send(AVL, a_, 0, 0, 0, -1, 1, 0, -1, 0, 0, "R6 empty set avail");
        // R7 fill lowest ways
        send(ALC, a_, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 alloc A");
        send(ALC, b_, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R7 alloc B");
        send(ALC, c_, 0, 0, 0, 0, 1, 0, 2, 0, 0, "R7 alloc C");
        send(ALC, a_, 0, 0, 0, 1, 0, 1, -1, 0, 0, "R8 alloc present");
        send(ACC, a_, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R7 new line Invalid");
        // R5 / R12 permissions
        send(SPM, a_, 0, 2, 0, -1, 1, 0, -1, 0, 0, "R12 set RO");
        send(ACC, a_, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 RO load");
        send(ACC, a_, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R5 RO fetch");
        send(ACC, a_, 2, 0, 0, 1, 0, 0, 0, 0, 0, "R5 RO store");
        send(ACC, a_, 3, 0, 0, 1, 0, 0, 0, 0, 0, "R5 RO atomic");
        send(SPM, b_, 0, 3, 0, -1, 1, 0, -1, 0, 0, "R12 set RW");
        send(ACC, b_, 2, 0, 0, 1, 1, 0, 1, 0, 0, "R5 RW store");
        send(SPM, mk(9, 1), 0, 3, 0, -1, 0, 1, -1, 0, 0, "R12 absent");
        send(4'hF, a_, 0, 0, 0, -1, 0, 1, -1, 0, 0, "R12 bad op");
        // R11 locks
        send(LKT, a_, 0, 0, 3, -1, 0, 0, -1, 0, 0, "R7 lock clear on alloc");
        send(LKS, a_, 0, 0, 3, -1, 1, 0, -1, 0, 0, "R11 lock set");
        send(LKT, a_, 0, 0, 3, -1, 1, 0, -1, 0, 0, "R11 test owner");
        send(LKT, a_, 0, 0, 5, -1, 0, 0, -1, 0, 0, "R11 test other");
        send(LKC, a_, 0, 0, 0, -1, 1, 0, -1, 0, 0, "R11 lock clear");
        send(LKT, a_, 0, 0, 3, -1, 0, 0, -1, 0, 0, "R11 test cleared");
        send(LKS, a_, 0, 0, 7, -1, 1, 0, -1, 0, 0, "R11 lock set again");
        send(LKS, mk(9, 1), 0, 0, 1, -1, 0, 1, -1, 0, 0, "R11 lock absent");
        // fill set, R6 / R8 / R10
        send(ALC, d_, 0, 0, 0, 0, 1, 0, 3, 0, 0, "R7 alloc D");
        send(AVL, mk(5, 1), 0, 0, 0, -1, 0, 0, -1, 0, 0, "R6 full set");
        send(AVL, a_, 0, 0, 0, -1, 1, 0, -1, 0, 0, "R6 match in full set");
        send(ALC, mk(5, 1), 0, 0, 0, 0, 0, 1, -1, 0, 0, "R8 alloc full");
        send(PRB, mk(5, 1), 0, 0, 0, -1, 1, 0, 2, 1, c_, "R10 victim C");
        send(TCH, c_, 0, 0, 0, 1, 1, 0, 2, 0, 0, "R13 touch C");
        send(PRB, mk(5, 1), 0, 0, 0, -1, 1, 0, 0, 1, a_, "R10 victim A");
        send(TCH, mk(9, 1), 0, 0, 0, 0, 0, 0, -1, 0, 0, "R13 touch absent");
        // R4 NotPresent
        send(SPM, a_, 0, 0, 0, -1, 1, 0, -1, 0, 0, "R12 set NP");
        send(ACC, a_, 0, 0, 0, 0, 0, 0, -1, 0, 0, "R4 NP miss");
        send(AVL, mk(5, 1), 0, 0, 0, -1, 1, 0, -1, 0, 0, "R6 NP way free");
        send(PRB, mk(5, 1), 0, 0, 0, -1, 0, 1, -1, 0, 0, "R10 probe with free way");
        send(ALC, mk(5, 1), 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 reuse NP way");
        send(LKT, mk(5, 1), 0, 0, 7, -1, 0, 0, -1, 0, 0, "R7 old lock gone");
        // R9 dealloc
        send(DAL, b_, 0, 0, 0, -1, 1, 0, -1, 0, 0, "R9 dealloc B");
        send(ACC, b_, 0, 0, 0, 0, 0, 0, -1, 0, 0, "R9 B gone");
        send(DAL, b_, 0, 0, 0, -1, 0, 1, -1, 0, 0, "R9 dealloc absent");
        send(ALC, mk(6, 1), 0, 0, 0, 0, 1, 0, 1, 0, 0, "R9 reuse freed way");
        // R1 set separation
        send(ACC, mk(1, 2), 0, 0, 0, 0, 0, 0, -1, 0, 0, "R1 other set empty");
        send(ALC, mk(3, 2), 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 other set way0");
        send(ACC, c_, 0, 0, 0, 1, 0, 0, 2, 0, 0, "R1 set1 C intact");

        repeat (2) @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "idle no response", rsp_valid, 0);
        chk(sb.size() == 0, "R2", "responses outstanding", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

endmodule